// File: doc/BRIEF.md
# Per-Locality Interrupt Mask and Status Unit

This unit keeps one interrupt enable word and one interrupt status word for each of five access localities, and drives a single interrupt line shared by all of them. Four kinds of event pulse arrive from neighbouring logic: data ready, status valid, owner changed and ready for command. Each pulse comes with the number of the locality it belongs to. A pulse is recorded in that locality's status word, and the line is raised, only when the locality has both its master enable and the matching source enable set.

Software reaches the registers through a simple access port. The port carries the locality of the access, a two-bit register select (0 enable, 1 status, 2 line number, 3 capability word), a write strobe and write data. The read data is combinational. The locality that currently owns the interface is supplied on `active_loc`. Enable and status writes have effect only when they come from that locality. Status bits are cleared by writing ones. The line number and capability words are read-only constants. The line is active high, and any polarity conversion happens downstream.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset, every locality's enable word reads 0x00000008 (polarity field bits 4:3 = 01, all else 0), every status word reads 0, and `irq_o` is 0.
- R2: An enable write from the active locality stores only bit 31 (master enable), bits 4:3 (polarity) and source bits 0, 1, 2 and 7. All other bits read back as 0.
- R3: Enable or status writes from a locality other than `active_loc` change nothing.
- R4: Source mapping for `ev_pulse`: bit 0 maps to status bit 0, bit 1 to status bit 1, bit 2 to status bit 2, and bit 3 to status bit 7. A pulse sets its status bit in the tagged locality, and raises `irq_o` one clock later, only if both that locality's master enable and the matching source enable are 1.
- R5: Events tagged with a locality number of 5 or more (including 0xFF) are discarded.
- R6: A status write from the active locality clears each supported bit (0, 1, 2, 7) written as 1. Other bits of the write are ignored, and status reads never show them.
- R7: After a status clear from the active locality, `irq_o` stays asserted while that locality still has a status bit set.
- R8: Register select 2 reads the fixed line number `LINE_NUM` (0 to 15) in bits 3:0, and writes to it are ignored.
- R9: Register select 3 reads the constant `CAP_WORD`, and writes to it are ignored.
- R10: `irq_o` is deasserted when a clear makes the writing locality's status zero, even if other localities still hold status bits.
- R11: When an event and a clear hit the same locality in the same cycle, the event wins: its bit ends set and the line stays or becomes asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_loc | input | 8 | Locality that currently owns the interface (0xFF = none) |
| acc_loc | input | 8 | Locality of the current register access |
| acc_sel | input | 2 | Register select: 0 enable, 1 status, 2 line number, 3 capability |
| acc_wr | input | 1 | Write strobe for the selected register |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for acc_loc/acc_sel (combinational) |
| ev_pulse | input | 4 | Event pulses: data ready, status valid, owner changed, ready for command |
| ev_loc | input | 8 | Locality tag for ev_pulse |
| irq_o | output | 1 | Shared interrupt line, active high |

## Verification
On every cycle, the assertions check four things. Every rise of the line follows a valid-locality event. Tagged events outside the locality range and writes from a foreign locality never move the line. Enable and status reads never expose unsupported bits. The line-number register always reads its constant. Only the directed scenarios can show the behaviours that need a value history: gating by master and source enable, partial versus complete clears, the line dropping while another locality still holds status, and an event racing a clear in the same cycle.

// File: rtl/loc_irq_unit.sv
module loc_irq_unit #(
  parameter int          NUM_LOC  = 5,
  parameter int          LOC_W    = 8,
  parameter int          LINE_NUM = 11,
  parameter logic [31:0] CAP_WORD = 32'h3000_0697
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic [LOC_W-1:0] acc_loc,
  input  logic [1:0]       acc_sel,
  input  logic             acc_wr,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      rd_data,
  input  logic [3:0]       ev_pulse,
  input  logic [LOC_W-1:0] ev_loc,
  output logic             irq_o
);
  localparam logic [1:0] SEL_EN  = 2'd0;
  localparam logic [1:0] SEL_ST  = 2'd1;
  localparam logic [1:0] SEL_VEC = 2'd2;
  localparam logic [1:0] POL_RST = 2'b01;

  function automatic logic [31:0] src_to_word(input logic [3:0] s);
    return {24'b0, s[3], 4'b0, s[2:0]};
  endfunction

  function automatic logic [3:0] word_to_src(input logic [31:0] w);
    return {w[7], w[2:0]};
  endfunction

  logic             gie_q [NUM_LOC];
  logic [1:0]       pol_q [NUM_LOC];
  logic [3:0]       src_q [NUM_LOC];
  logic [3:0]       st_q  [NUM_LOC];
  logic [NUM_LOC-1:0] latch_any;
  logic [NUM_LOC-1:0] drop_req;

  genvar g;
  generate
    for (g = 0; g < NUM_LOC; g++) begin : g_loc
      logic       is_ev, wr_ok;
      logic [3:0] set_v, clr_v, kept;

      assign is_ev = (ev_loc == LOC_W'(g));
      assign wr_ok = acc_wr && (acc_loc == LOC_W'(g)) && (active_loc == LOC_W'(g));
      assign set_v = is_ev ? (ev_pulse & src_q[g] & {4{gie_q[g]}}) : 4'b0;
      assign clr_v = (wr_ok && acc_sel == SEL_ST) ? word_to_src(acc_wdata) : 4'b0;
      assign kept  = st_q[g] & ~clr_v;

      assign latch_any[g] = |set_v;
      assign drop_req[g]  = (|clr_v) && (|st_q[g]) && (kept == 4'b0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gie_q[g] <= 1'b0;
          pol_q[g] <= POL_RST;
          src_q[g] <= 4'b0;
          st_q[g]  <= 4'b0;
        end else begin
          st_q[g] <= kept | set_v;
          if (wr_ok && acc_sel == SEL_EN) begin
            gie_q[g] <= acc_wdata[31];
            pol_q[g] <= acc_wdata[4:3];
            src_q[g] <= word_to_src(acc_wdata);
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_o <= 1'b0;
    else if (|latch_any) irq_o <= 1'b1;
    else if (|drop_req)  irq_o <= 1'b0;
  end

  always_comb begin
    logic [31:0] en_w, st_w;
    en_w = 32'b0;
    st_w = 32'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (acc_loc == LOC_W'(i)) begin
        en_w = {gie_q[i], 26'b0, pol_q[i], 3'b0} | src_to_word(src_q[i]);
        st_w = src_to_word(st_q[i]);
      end
    end
    case (acc_sel)
      SEL_EN:  rd_data = en_w;
      SEL_ST:  rd_data = st_w;
      SEL_VEC: rd_data = {28'b0, 4'(LINE_NUM)};
      default: rd_data = CAP_WORD;
    endcase
  end
endmodule

module loc_irq_unit_chk #(
  parameter int NUM_LOC  = 5,
  parameter int LOC_W    = 8,
  parameter int LINE_NUM = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LOC_W-1:0] active_loc,
  input logic [LOC_W-1:0] acc_loc,
  input logic [1:0]       acc_sel,
  input logic             acc_wr,
  input logic [31:0]      rd_data,
  input logic [3:0]       ev_pulse,
  input logic [LOC_W-1:0] ev_loc,
  input logic             irq_o
);
  logic ev_valid, ev_bad;
  assign ev_valid = (|ev_pulse) && (ev_loc < LOC_W'(NUM_LOC));
  assign ev_bad   = (|ev_pulse) && (ev_loc >= LOC_W'(NUM_LOC));

  assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ev_valid));

  assert_bad_loc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bad && !acc_wr) |=> $stable(irq_o));

  assert_foreign_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_loc != active_loc && !ev_valid) |=> $stable(irq_o));

  assert_enable_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel == 2'd0) |-> ((rd_data & ~32'h8000_009F) == 32'b0));

  assert_status_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel == 2'd1) |-> ((rd_data & ~32'h0000_0087) == 32'b0));

  assert_vector_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel == 2'd2) |-> (rd_data == 32'(LINE_NUM)));
endmodule

bind loc_irq_unit loc_irq_unit_chk #(
  .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .LINE_NUM(LINE_NUM)
) chk_i (
  .clk(clk), .rst_n(rst_n), .active_loc(active_loc), .acc_loc(acc_loc),
  .acc_sel(acc_sel), .acc_wr(acc_wr), .rd_data(rd_data),
  .ev_pulse(ev_pulse), .ev_loc(ev_loc), .irq_o(irq_o)
);

// File: tb/loc_irq_unit_tb_top.sv
`timescale 1ns/1ps
module loc_irq_unit_tb_top;
  localparam int          LINE = 11;
  localparam logic [31:0] CAP  = 32'h3000_0697;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  active_loc = 8'hFF, acc_loc = 8'd0, ev_loc = 8'd0;
  logic [1:0]  acc_sel = 2'd0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = 32'd0, rd_data;
  logic [3:0]  ev_pulse = 4'd0;
  logic        irq_o;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  loc_irq_unit #(.LINE_NUM(LINE), .CAP_WORD(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .active_loc(active_loc), .acc_loc(acc_loc),
    .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .ev_pulse(ev_pulse), .ev_loc(ev_loc), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic [7:0] loc, input logic [1:0] sel,
                       input logic [31:0] d, input logic [3:0] ev, input logic [7:0] el);
    @(negedge clk);
    acc_wr = wr; acc_loc = loc; acc_sel = sel; acc_wdata = d;
    ev_pulse = ev; ev_loc = el;
    @(negedge clk);
    acc_wr = 1'b0; ev_pulse = 4'd0; acc_wdata = 32'd0;
  endtask

  task automatic wr(input logic [7:0] loc, input logic [1:0] sel, input logic [31:0] d);
    cycle(1'b1, loc, sel, d, 4'd0, 8'd0);
  endtask

  task automatic ev(input logic [3:0] m, input logic [7:0] l);
    cycle(1'b0, 8'd0, 2'd0, 32'd0, m, l);
  endtask

  task automatic rd(input logic [7:0] loc, input logic [1:0] sel, output logic [31:0] v);
    acc_wr = 1'b0; acc_loc = loc; acc_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(8'(i), 2'd0, v); chk("R1 enable reset", v, 32'h8);
      rd(8'(i), 2'd1, v); chk("R1 status reset", v, 32'h0);
    end
    chk("R1 line reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_enable_mask;
    logic [31:0] v;
    active_loc = 8'd0;
    wr(8'd0, 2'd0, 32'hFFFF_FFFF);
    rd(8'd0, 2'd0, v); chk("R2 writable enable bits", v, 32'h8000_009F);
    wr(8'd0, 2'd0, 32'h0);
    rd(8'd0, 2'd0, v); chk("R2 enable cleared", v, 32'h0);
  endtask

  task automatic t_foreign;
    logic [31:0] v;
    active_loc = 8'd0;
    wr(8'd1, 2'd0, 32'h8000_0001);
    rd(8'd1, 2'd0, v); chk("R3 foreign enable write ignored", v, 32'h8);
  endtask

  task automatic t_gating;
    logic [31:0] v;
    active_loc = 8'd0;
    wr(8'd0, 2'd0, 32'h8000_0001);
    ev(4'b0010, 8'd0);
    rd(8'd0, 2'd1, v); chk("R4 masked source not latched", v, 32'h0);
    chk("R4 masked source no line", {31'b0, irq_o}, 32'h0);
    ev(4'b0001, 8'd0);
    rd(8'd0, 2'd1, v); chk("R4 enabled source latched", v, 32'h1);
    chk("R4 line raised", {31'b0, irq_o}, 32'h1);
    wr(8'd0, 2'd1, 32'h1);
    chk("R10 line drop on zero", {31'b0, irq_o}, 32'h0);
    wr(8'd0, 2'd0, 32'h0000_0081);
    ev(4'b1000, 8'd0);
    rd(8'd0, 2'd1, v); chk("R4 no master enable no latch", v, 32'h0);
    chk("R4 no master enable no line", {31'b0, irq_o}, 32'h0);
    wr(8'd0, 2'd0, 32'h8000_0080);
    ev(4'b1000, 8'd0);
    rd(8'd0, 2'd1, v); chk("R4 ready-for-command maps to bit 7", v, 32'h80);
    wr(8'd0, 2'd1, 32'h80);
  endtask

  task automatic t_bad_loc;
    logic [31:0] v;
    active_loc = 8'd0;
    wr(8'd0, 2'd0, 32'h8000_0087);
    ev(4'hF, 8'hFF);
    ev(4'hF, 8'd5);
    for (int i = 0; i < 5; i++) begin
      rd(8'(i), 2'd1, v); chk("R5 bad locality discarded", v, 32'h0);
    end
    chk("R5 bad locality no line", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    active_loc = 8'd1;
    wr(8'd1, 2'd0, 32'h8000_0004);
    ev(4'b0100, 8'd1);
    active_loc = 8'd0;
    ev(4'b1001, 8'd0);
    rd(8'd0, 2'd1, v); chk("R4 two sources latched", v, 32'h81);
    wr(8'd0, 2'd1, 32'hFFFF_FF01 & ~32'h80);
    rd(8'd0, 2'd1, v); chk("R6 partial clear", v, 32'h80);
    chk("R7 line held while bits remain", {31'b0, irq_o}, 32'h1);
    wr(8'd1, 2'd1, 32'h4);
    rd(8'd1, 2'd1, v); chk("R3 foreign status clear ignored", v, 32'h4);
    wr(8'd0, 2'd1, 32'h80);
    rd(8'd0, 2'd1, v); chk("R6 full clear", v, 32'h0);
    chk("R10 line drops despite other locality", {31'b0, irq_o}, 32'h0);
    active_loc = 8'd1;
    wr(8'd1, 2'd1, 32'h4);
    rd(8'd1, 2'd1, v); chk("R6 clear from new owner", v, 32'h0);
  endtask

  task automatic t_vec_cap;
    logic [31:0] v;
    active_loc = 8'd0;
    wr(8'd0, 2'd2, 32'h5);
    rd(8'd0, 2'd2, v); chk("R8 line number fixed", v, 32'(LINE));
    wr(8'd0, 2'd3, 32'h0);
    rd(8'd2, 2'd3, v); chk("R9 capability constant", v, CAP);
  endtask

  task automatic t_race;
    logic [31:0] v;
    active_loc = 8'd0;
    wr(8'd0, 2'd0, 32'h8000_0087);
    ev(4'b0001, 8'd0);
    cycle(1'b1, 8'd0, 2'd1, 32'h1, 4'b0010, 8'd0);
    rd(8'd0, 2'd1, v); chk("R11 event beats clear other bit", v, 32'h2);
    chk("R11 line held", {31'b0, irq_o}, 32'h1);
    cycle(1'b1, 8'd0, 2'd1, 32'h2, 4'b0010, 8'd0);
    rd(8'd0, 2'd1, v); chk("R11 event beats clear same bit", v, 32'h2);
    chk("R11 line still held", {31'b0, irq_o}, 32'h1);
    wr(8'd0, 2'd1, 32'h2);
    chk("R10 final drop", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_mask();
        t_foreign();
        t_gating();
        t_bad_loc();
        t_clear();
        t_vec_cap();
        t_race();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule